// File: doc/BRIEF.md
# Descriptor Queue Engine

This block walks chains of packet buffer descriptors in a local descriptor RAM, one chain per channel, for eight channels. Software builds the descriptors through a host port on the RAM and starts a channel by writing that channel's head pointer. The engine reads each descriptor (four 32-bit words). It checks that software has handed the packet over and raises one buffer transfer request per descriptor on a request/done handshake. When a packet ends, it writes the flags back to hand the packet to software. It then follows the next pointer or halts the channel.

Ownership is granted per packet. Only the first descriptor of a packet carries and returns the ownership bit. When the engine halts on a null next pointer it marks that descriptor with an end-of-queue flag. Software can then detect that a pointer it patched in later was never seen, and can restart the channel. A teardown request ends a channel cleanly at the next packet boundary. Channels are served one whole packet at a time, in fixed-priority or round-robin order.

Top module: `dq_engine`

## Requirements
- R1: After reset, writing a non-zero word address to an idle channel's head pointer activates that channel and clears its two error bits. A zero head write, or any head write to an active channel, has no effect.
- R2: The first descriptor of a packet must have flag bit 31 (start of packet) and flag bit 29 (owned by engine) set in word 3. If it does not, the channel halts, its ownership error bit is set, no transfer is issued, and the descriptor is left unchanged.
- R3: Each descriptor gives one transfer request. The channel, length (word 2 bits 15:0) and address (word 1, plus word 2 bits 31:16 on the start descriptor only) are held stable until done. Request flags mark the start and end (flag bit 30) descriptors. The pass-CRC output repeats flag bit 26 of the packet's start descriptor.
- R4: After the end-of-packet descriptor, word 3 of the start descriptor is rewritten with bit 29 cleared and every other bit kept. Bit 28 (end of queue) is set in the end descriptor when its next pointer is zero.
- R5: A channel's completion pointer holds the word address of the end descriptor of its last completed packet. The channel then continues at the next pointer, or halts when that pointer is zero.
- R6: A next pointer is read once. If it was zero, patching it after the halt does not restart the channel. A new head write does.
- R7: If the fragment lengths of a packet do not sum to the packet length (word 3 bits 15:0), the length error bit is set and the packet still completes. A fragment with no end flag and a zero next pointer sets the length error bit and halts the channel without any write-back.
- R8: A teardown on an active channel takes effect at the start of the next packet. That descriptor gets bit 27 set and bit 29 cleared, it becomes the completion pointer, the channel halts and nothing more is transferred. A teardown on an idle channel is ignored.
- R9: With the mode input low, the lowest-numbered active channel is served next, one whole packet per grant.
- R10: With the mode input high, the next active channel after the one served last, in increasing order with wrap-around, is served.
- R11: A host RAM access is always performed in the cycle it is presented, and the engine waits. Host read data appears on the read data output one cycle later.
- R12: After reset no channel is active, no request is raised, and all completion pointers and error bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 fixed priority, 1 round-robin |
| hp_wr | input | 1 | Head pointer write strobe |
| hp_ch | input | 3 | Head pointer channel |
| hp_ptr | input | 8 | Head descriptor word address |
| td_req | input | 1 | Teardown strobe |
| td_ch | input | 3 | Teardown channel |
| hst_en | input | 1 | Host RAM access enable |
| hst_we | input | 1 | Host RAM write |
| hst_addr | input | 8 | Host RAM word address |
| hst_wdata | input | 32 | Host RAM write data |
| hst_rdata | output | 32 | RAM read data |
| xfer_req | output | 1 | Transfer request |
| xfer_ch | output | 3 | Requesting channel |
| xfer_addr | output | 32 | Buffer byte address |
| xfer_len | output | 16 | Buffer byte length |
| xfer_sop | output | 1 | First descriptor of packet |
| xfer_eop | output | 1 | Last descriptor of packet |
| xfer_pass_crc | output | 1 | CRC already in lengths |
| xfer_done | input | 1 | Transfer finished |
| ch_active | output | 8 | Per-channel active |
| ch_err_own | output | 8 | Per-channel ownership error |
| ch_err_len | output | 8 | Per-channel length error |
| cp_flat | output | 64 | Completion pointers, channel i at bits 8i+7:8i |

## Verification
The bench targets five corner cases:
- An offset in a middle fragment must not move the transfer address. A design that applies it sends the fragment to the wrong buffer.
- A zero next pointer patched after the halt must not restart the channel. An engine that re-reads the pointer would issue a transfer that was never expected.
- A teardown requested mid-packet must let that packet finish and then mark the following start descriptor. Acting early would cut a packet short, and acting late would send one packet too many.
- The arbitration order is run so that fixed and round-robin give different sequences from the same queued work.
- A host read burst must stall descriptor fetches while still returning correct data.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int FL_SOP  = 31;
  localparam int FL_EOP  = 30;
  localparam int FL_OWN  = 29;
  localparam int FL_EOQ  = 28;
  localparam int FL_TDN  = 27;
  localparam int FL_PCRC = 26;

  typedef enum logic [3:0] {
    W_IDLE, W_FETCH, W_CAPT, W_CHECK, W_XFER, W_AFTER,
    W_WB_EOP, W_WB_SOP, W_WB_TDN, W_FIN
  } wstate_t;
endpackage

// File: rtl/dq_ram.sv
module dq_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          hst_en,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  input  logic          eng_req,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [31:0]   eng_wdata,
  output logic          eng_gnt,
  output logic [31:0]   rdata
);
  logic [31:0]   mem [DEPTH];
  logic          sel_en, sel_we;
  logic [AW-1:0] sel_addr;
  logic [31:0]   sel_wdata;

  // host wins every cycle it is present
  always_comb begin
    eng_gnt   = eng_req && !hst_en;
    sel_en    = hst_en || eng_req;
    sel_we    = hst_en ? hst_we    : eng_we;
    sel_addr  = hst_en ? hst_addr  : eng_addr;
    sel_wdata = hst_en ? hst_wdata : eng_wdata;
  end

  always_ff @(posedge clk) begin
    if (sel_en) begin
      if (sel_we) mem[sel_addr] <= sel_wdata;
      else        rdata <= mem[sel_addr];
    end
  end
endmodule

// File: rtl/dq_arb.sv
module dq_arb #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_l,
  input  logic [NCH-1:0] req,
  input  logic           rr_mode,
  input  logic           take,
  output logic           gnt_vld,
  output logic [CW-1:0]  gnt_idx
);
  logic [CW-1:0] last_q, last_d;
  int pos;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    pos     = 0;
    if (!rr_mode) begin
      for (int k = NCH - 1; k >= 0; k--) begin
        if (req[k]) begin
          gnt_vld = 1'b1;
          gnt_idx = CW'(k);
        end
      end
    end else begin
      for (int off = NCH; off >= 1; off--) begin
        pos = (int'(last_q) + off) % NCH;
        if (req[pos]) begin
          gnt_vld = 1'b1;
          gnt_idx = CW'(pos);
        end
      end
    end
    last_d = take ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) last_q <= CW'(NCH - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/dq_chan.sv
module dq_chan #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          hp_sel,
  input  logic [AW-1:0] hp_ptr,
  input  logic          td_sel,
  input  logic          upd_hit,
  input  logic          upd_halt,
  input  logic [AW-1:0] upd_next,
  input  logic          upd_cp_en,
  input  logic [AW-1:0] upd_cp,
  input  logic          upd_eown,
  input  logic          upd_elen,
  output logic          active,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] cp,
  output logic          eown,
  output logic          elen,
  output logic          tdp
);
  logic          act_d, eown_d, elen_d, tdp_d;
  logic [AW-1:0] ptr_d, cp_d;

  always_comb begin
    act_d = active; ptr_d = ptr; cp_d = cp;
    eown_d = eown; elen_d = elen; tdp_d = tdp;
    if (hp_sel && !active) begin
      act_d = 1'b1; ptr_d = hp_ptr;
      eown_d = 1'b0; elen_d = 1'b0; tdp_d = 1'b0;
    end
    if (td_sel && active) tdp_d = 1'b1;
    if (upd_hit) begin
      if (upd_halt) begin
        act_d = 1'b0;
        tdp_d = 1'b0;
      end else begin
        ptr_d = upd_next;
      end
      if (upd_cp_en) cp_d = upd_cp;
      eown_d = eown || upd_eown;
      elen_d = elen || upd_elen;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      active <= 1'b0; ptr <= '0; cp <= '0;
      eown <= 1'b0; elen <= 1'b0; tdp <= 1'b0;
    end else begin
      active <= act_d; ptr <= ptr_d; cp <= cp_d;
      eown <= eown_d; elen <= elen_d; tdp <= tdp_d;
    end
  end
endmodule

// File: rtl/dq_walker.sv
module dq_walker
  import dq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_l,
  input  logic           gnt_vld,
  input  logic [CW-1:0]  gnt_idx,
  input  logic [AW-1:0]  ptr_in,
  input  logic [NCH-1:0] td_in,
  output logic           take,
  output logic           eng_req,
  output logic           eng_we,
  output logic [AW-1:0]  eng_addr,
  output logic [31:0]    eng_wdata,
  input  logic           eng_gnt,
  input  logic [31:0]    rdata,
  output logic           xfer_req,
  output logic [CW-1:0]  xfer_ch,
  output logic [31:0]    xfer_addr,
  output logic [15:0]    xfer_len,
  output logic           xfer_sop,
  output logic           xfer_eop,
  output logic           xfer_pass_crc,
  input  logic           xfer_done,
  output logic           upd_vld,
  output logic [CW-1:0]  upd_ch,
  output logic           upd_halt,
  output logic [AW-1:0]  upd_next,
  output logic           upd_cp_en,
  output logic [AW-1:0]  upd_cp,
  output logic           upd_eown,
  output logic           upd_elen
);
  localparam logic [31:0] M_OWN = 32'(1) << FL_OWN;
  localparam logic [31:0] M_EOQ = 32'(1) << FL_EOQ;
  localparam logic [31:0] M_TDN = 32'(1) << FL_TDN;

  wstate_t        st_q, st_d;
  logic [CW-1:0]  ch_q, ch_d;
  logic [AW-1:0]  cur_q, cur_d, sop_q, sop_d;
  logic [1:0]     idx_q, idx_d;
  logic [3:0][31:0] dw_q, dw_d;
  logic [31:0]    sw3_q, sw3_d, sum_q, sum_d;
  logic [15:0]    plen_q, plen_d;
  logic           first_q, first_d, pcrc_q, pcrc_d;
  logic           nul;

  assign nul           = (dw_q[0] == '0);
  assign xfer_req      = (st_q == W_XFER);
  assign xfer_ch       = ch_q;
  assign xfer_len      = dw_q[2][15:0];
  assign xfer_addr     = dw_q[1] + (first_q ? {16'b0, dw_q[2][31:16]} : 32'b0);
  assign xfer_sop      = first_q;
  assign xfer_eop      = dw_q[3][FL_EOP];
  assign xfer_pass_crc = pcrc_q;
  assign upd_ch        = ch_q;
  assign upd_next      = dw_q[0][AW-1:0];

  always_comb begin
    st_d = st_q; ch_d = ch_q; cur_d = cur_q; sop_d = sop_q; idx_d = idx_q;
    dw_d = dw_q; sw3_d = sw3_q; sum_d = sum_q; plen_d = plen_q;
    first_d = first_q; pcrc_d = pcrc_q;
    take = 1'b0; eng_req = 1'b0; eng_we = 1'b0; eng_addr = '0; eng_wdata = '0;
    upd_vld = 1'b0; upd_halt = 1'b0; upd_cp_en = 1'b0; upd_cp = cur_q;
    upd_eown = 1'b0; upd_elen = 1'b0;
    unique case (st_q)
      W_IDLE: if (gnt_vld) begin
        take = 1'b1; ch_d = gnt_idx; cur_d = ptr_in;
        idx_d = '0; first_d = 1'b1; st_d = W_FETCH;
      end
      W_FETCH: begin
        eng_req = 1'b1; eng_addr = cur_q + AW'(idx_q);
        if (eng_gnt) st_d = W_CAPT;
      end
      W_CAPT: begin
        dw_d[idx_q] = rdata;
        if (idx_q == 2'd3) st_d = W_CHECK;
        else begin
          idx_d = idx_q + 2'd1;
          st_d  = W_FETCH;
        end
      end
      W_CHECK: begin
        if (!first_q) st_d = W_XFER;
        else if (td_in[ch_q]) st_d = W_WB_TDN;
        else if (!dw_q[3][FL_SOP] || !dw_q[3][FL_OWN]) begin
          upd_vld = 1'b1; upd_halt = 1'b1; upd_eown = 1'b1; st_d = W_IDLE;
        end else begin
          sop_d = cur_q; sw3_d = dw_q[3]; plen_d = dw_q[3][15:0];
          pcrc_d = dw_q[3][FL_PCRC]; sum_d = '0; st_d = W_XFER;
        end
      end
      W_XFER: if (xfer_done) begin
        sum_d = sum_q + {16'b0, dw_q[2][15:0]};
        st_d  = W_AFTER;
      end
      W_AFTER: begin
        if (dw_q[3][FL_EOP]) st_d = (nul && cur_q != sop_q) ? W_WB_EOP : W_WB_SOP;
        else if (nul) begin
          upd_vld = 1'b1; upd_halt = 1'b1; upd_elen = 1'b1; st_d = W_IDLE;
        end else begin
          cur_d = dw_q[0][AW-1:0]; idx_d = '0; first_d = 1'b0; st_d = W_FETCH;
        end
      end
      W_WB_EOP: begin
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = cur_q + AW'(3);
        eng_wdata = dw_q[3] | M_EOQ;
        if (eng_gnt) st_d = W_WB_SOP;
      end
      W_WB_SOP: begin
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = sop_q + AW'(3);
        eng_wdata = (sw3_q & ~M_OWN) | ((nul && cur_q == sop_q) ? M_EOQ : 32'b0);
        if (eng_gnt) st_d = W_FIN;
      end
      W_WB_TDN: begin
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = cur_q + AW'(3);
        eng_wdata = (dw_q[3] | M_TDN) & ~M_OWN;
        if (eng_gnt) begin
          upd_vld = 1'b1; upd_halt = 1'b1; upd_cp_en = 1'b1; st_d = W_IDLE;
        end
      end
      W_FIN: begin
        upd_vld = 1'b1; upd_halt = nul; upd_cp_en = 1'b1;
        upd_elen = (sum_q != {16'b0, plen_q}); st_d = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= W_IDLE; ch_q <= '0; cur_q <= '0; sop_q <= '0; idx_q <= '0;
      dw_q <= '0; sw3_q <= '0; sum_q <= '0; plen_q <= '0;
      first_q <= 1'b0; pcrc_q <= 1'b0;
    end else begin
      st_q <= st_d; ch_q <= ch_d; cur_q <= cur_d; sop_q <= sop_d; idx_q <= idx_d;
      dw_q <= dw_d; sw3_q <= sw3_d; sum_q <= sum_d; plen_q <= plen_d;
      first_q <= first_d; pcrc_q <= pcrc_d;
    end
  end
endmodule

// File: rtl/dq_engine.sv
module dq_engine #(
  parameter int NCH   = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rr_mode,
  input  logic            hp_wr,
  input  logic [CW-1:0]   hp_ch,
  input  logic [AW-1:0]   hp_ptr,
  input  logic            td_req,
  input  logic [CW-1:0]   td_ch,
  input  logic            hst_en,
  input  logic            hst_we,
  input  logic [AW-1:0]   hst_addr,
  input  logic [31:0]     hst_wdata,
  output logic [31:0]     hst_rdata,
  output logic            xfer_req,
  output logic [CW-1:0]   xfer_ch,
  output logic [31:0]     xfer_addr,
  output logic [15:0]     xfer_len,
  output logic            xfer_sop,
  output logic            xfer_eop,
  output logic            xfer_pass_crc,
  input  logic            xfer_done,
  output logic [NCH-1:0]  ch_active,
  output logic [NCH-1:0]  ch_err_own,
  output logic [NCH-1:0]  ch_err_len,
  output logic [NCH*AW-1:0] cp_flat
);
  logic [1:0]     rs_q;
  logic           rst_l;
  logic           gnt_vld, take, eng_req, eng_we, eng_gnt;
  logic [CW-1:0]  gnt_idx, upd_ch;
  logic [AW-1:0]  eng_addr, upd_next, upd_cp;
  logic [31:0]    eng_wdata;
  logic           upd_vld, upd_halt, upd_cp_en, upd_eown, upd_elen;
  logic [AW-1:0]  ptr_arr [NCH];
  logic [AW-1:0]  cp_arr  [NCH];
  logic [NCH-1:0] tdp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  dq_ram #(.DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk, .hst_en, .hst_we, .hst_addr, .hst_wdata,
    .eng_req, .eng_we, .eng_addr, .eng_wdata, .eng_gnt, .rdata(hst_rdata)
  );

  dq_arb #(.NCH(NCH), .CW(CW)) arb_i (
    .clk, .rst_l, .req(ch_active), .rr_mode, .take, .gnt_vld, .gnt_idx
  );

  dq_walker #(.NCH(NCH), .AW(AW), .CW(CW)) walk_i (
    .clk, .rst_l, .gnt_vld, .gnt_idx, .ptr_in(ptr_arr[gnt_idx]), .td_in(tdp),
    .take, .eng_req, .eng_we, .eng_addr, .eng_wdata, .eng_gnt, .rdata(hst_rdata),
    .xfer_req, .xfer_ch, .xfer_addr, .xfer_len, .xfer_sop, .xfer_eop,
    .xfer_pass_crc, .xfer_done, .upd_vld, .upd_ch, .upd_halt, .upd_next,
    .upd_cp_en, .upd_cp, .upd_eown, .upd_elen
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dq_chan #(.AW(AW)) chan_i (
      .clk, .rst_l,
      .hp_sel(hp_wr && hp_ch == CW'(i) && hp_ptr != '0),
      .hp_ptr,
      .td_sel(td_req && td_ch == CW'(i)),
      .upd_hit(upd_vld && upd_ch == CW'(i)),
      .upd_halt, .upd_next, .upd_cp_en, .upd_cp, .upd_eown, .upd_elen,
      .active(ch_active[i]), .ptr(ptr_arr[i]), .cp(cp_arr[i]),
      .eown(ch_err_own[i]), .elen(ch_err_len[i]), .tdp(tdp[i])
    );
    assign cp_flat[i*AW +: AW] = cp_arr[i];
  end
endmodule

// File: rtl/dq_engine_chk.sv
module dq_engine_chk #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hp_wr,
  input logic           xfer_req,
  input logic           xfer_done,
  input logic [CW-1:0]  xfer_ch,
  input logic [31:0]    xfer_addr,
  input logic [15:0]    xfer_len,
  input logic [NCH-1:0] ch_active,
  input logic [NCH-1:0] ch_err_own
);
  // R3
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr)
      && $stable(xfer_len) && $stable(xfer_ch));

  // R3
  xfer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> !xfer_req);

  // R5
  xfer_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> ch_active[xfer_ch]);

  // R2
  own_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_err_own & ~$past(ch_err_own)) != '0)
      |-> ((ch_err_own & ~$past(ch_err_own) & ch_active) == '0));

  // R1
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_active & ~$past(ch_active)) != '0) |-> $past(hp_wr));
endmodule

bind dq_engine dq_engine_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hp_wr(hp_wr), .xfer_req(xfer_req),
  .xfer_done(xfer_done), .xfer_ch(xfer_ch), .xfer_addr(xfer_addr),
  .xfer_len(xfer_len), .ch_active(ch_active), .ch_err_own(ch_err_own)
);

// File: tb/dq_engine_tb.sv
module dq_engine_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000, OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000, TDN = 32'h0800_0000, PCR = 32'h0400_0000;

  logic clk = 1'b0, rst_n = 1'b0, rr_mode = 1'b0;
  logic hp_wr = 1'b0, td_req = 1'b0, hst_en = 1'b0, hst_we = 1'b0, xfer_done = 1'b0;
  logic [2:0] hp_ch = '0, td_ch = '0, xfer_ch;
  logic [7:0] hp_ptr = '0, hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata, xfer_addr;
  logic [15:0] xfer_len;
  logic xfer_req, xfer_sop, xfer_eop, xfer_pass_crc;
  logic [7:0] ch_active, ch_err_own, ch_err_len;
  logic [63:0] cp_flat;

  int checks = 0, errors = 0, resp_delay = 2, cnt = 0;
  logic req_prev = 1'b0;
  logic [63:0] exp_q[$];
  string exp_tag[$];

  always #(CLK_P/2) clk = ~clk;

  dq_engine dut_i (.*);

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(int ch, bit s, bit e, bit p, int len, logic [31:0] a);
    return {9'b0, ch[3:0], s, e, p, len[15:0], a};
  endfunction

  task automatic expect_x(string tag, int ch, bit s, bit e, bit p, int len, logic [31:0] a);
    exp_q.push_back(mk(ch, s, e, p, len, a));
    exp_tag.push_back(tag);
  endtask

  // reference comparison and transfer responder, every clock
  always @(negedge clk) begin
    if (rst_n && xfer_req && !req_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected transfer", {xfer_ch, xfer_addr}, 0);
      else begin
        logic [63:0] act, e;
        string t;
        act = mk(xfer_ch, xfer_sop, xfer_eop, xfer_pass_crc, xfer_len, xfer_addr);
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(act == e, t, act, e);
      end
    end
    req_prev = xfer_req;
    if (xfer_done) xfer_done = 1'b0;
    else if (xfer_req) begin
      if (cnt >= resp_delay) begin xfer_done = 1'b1; cnt = 0; end
      else cnt++;
    end
  end

  task automatic hwr(int a, logic [31:0] d);
    @(negedge clk); hst_en = 1; hst_we = 1; hst_addr = a[7:0]; hst_wdata = d;
    @(negedge clk); hst_en = 0; hst_we = 0;
  endtask

  task automatic hrd(int a, output logic [31:0] d);
    @(negedge clk); hst_en = 1; hst_we = 0; hst_addr = a[7:0];
    @(negedge clk); d = hst_rdata; hst_en = 0;
  endtask

  task automatic desc(int a, int nx, logic [31:0] bp, int off, int len, logic [31:0] fl, int pl);
    hwr(a, nx); hwr(a + 1, bp);
    hwr(a + 2, {off[15:0], len[15:0]}); hwr(a + 3, fl | {16'b0, pl[15:0]});
  endtask

  task automatic head(int ch, int p);
    @(negedge clk); hp_wr = 1; hp_ch = ch[2:0]; hp_ptr = p[7:0];
    @(negedge clk); hp_wr = 0;
  endtask

  task automatic tdown(int ch);
    @(negedge clk); td_req = 1; td_ch = ch[2:0];
    @(negedge clk); td_req = 0;
  endtask

  task automatic wait_idle(string tag);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ch_active == 0 && !xfer_req) break;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (xfer_req) break;
    end
  endtask

  task automatic word(int a, logic [31:0] e, string tag);
    logic [31:0] d;
    hrd(a, d);
    chk(d == e, tag, d, e);
  endtask

  function automatic logic [7:0] cp(int ch);
    return cp_flat[ch*8 +: 8];
  endfunction

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(ch_active == 0 && !xfer_req, "R12 idle after reset", {ch_active, xfer_req}, 0);
    chk(cp_flat == 0 && ch_err_own == 0 && ch_err_len == 0, "R12 pointers and errors zero",
        cp_flat, 0);

    // R1 zero head write ignored
    head(3, 0);
    repeat (3) @(negedge clk);
    chk(ch_active == 0, "R1 zero head ignored", ch_active, 0);

    // R3 R4 R5: two single-buffer packets, offset on first, pass-CRC on second
    desc(16, 20, 32'h1000, 4, 60, SOP | EOP | OWN, 60);
    desc(20, 0, 32'h2000, 0, 100, SOP | EOP | OWN | PCR, 100);
    expect_x("R3 offset applied", 2, 1, 1, 0, 60, 32'h1004);
    expect_x("R3 pass crc", 2, 1, 1, 1, 100, 32'h2000);
    head(2, 16);
    wait_idle("R5 list drained");
    word(19, SOP | EOP | 60, "R4 owner cleared no eoq");
    word(23, SOP | EOP | EOQ | PCR | 100, "R4 eoq on last");
    chk(cp(2) == 20, "R5 completion pointer", cp(2), 20);

    // R3 R4 fragmented packet, offset in middle fragment must be ignored
    desc(32, 36, 32'h3000, 2, 10, SOP | OWN, 30);
    desc(36, 40, 32'h3100, 7, 12, 0, 0);
    desc(40, 0, 32'h3200, 0, 8, EOP, 0);
    expect_x("R3 fragment sop", 0, 1, 0, 0, 10, 32'h3002);
    expect_x("R3 middle offset ignored", 0, 0, 0, 0, 12, 32'h3100);
    expect_x("R3 fragment eop", 0, 0, 1, 0, 8, 32'h3200);
    head(0, 32);
    wait_idle("R3 fragments done");
    word(35, SOP | 30, "R4 sop written back");
    word(43, EOP | EOQ, "R4 eoq on eop descriptor");
    word(39, 0, "R4 middle untouched");
    chk(cp(0) == 40 && ch_err_len[0] == 0, "R5 cp at eop", cp(0), 40);

    // R2 owner missing
    desc(48, 0, 32'h5000, 0, 5, SOP | EOP, 5);
    head(1, 48);
    wait_idle("R2 no transfer");
    chk(ch_err_own[1] == 1 && ch_active[1] == 0, "R2 error and halt", ch_err_own, 2);
    word(51, SOP | EOP | 5, "R2 descriptor unchanged");
    chk(cp(1) == 0, "R2 cp unchanged", cp(1), 0);

    // R7 length mismatch and truncated fragment
    desc(52, 0, 32'h6000, 0, 20, SOP | EOP | OWN, 24);
    expect_x("R7 mismatch still sent", 4, 1, 1, 0, 20, 32'h6000);
    head(4, 52);
    wait_idle("R7 mismatch done");
    chk(ch_err_len[4] == 1, "R7 length error", ch_err_len, 8'h10);
    word(55, SOP | EOP | EOQ | 24, "R7 packet completed");
    desc(56, 0, 32'h6100, 0, 9, SOP | OWN, 9);
    expect_x("R7 truncated fragment", 5, 1, 0, 0, 9, 32'h6100);
    head(5, 56);
    wait_idle("R7 truncated done");
    chk(ch_err_len[5] == 1 && cp(5) == 0, "R7 truncated error", {ch_err_len, cp(5)}, 16'h3000);
    word(59, SOP | OWN | 9, "R7 no write-back");

    // R6 patch after halt has no effect
    desc(24, 0, 32'h4000, 0, 40, SOP | EOP | OWN, 40);
    hwr(20, 24);
    repeat (30) @(negedge clk);
    chk(ch_active[2] == 0, "R6 patched pointer not followed", ch_active, 0);
    expect_x("R6 restart by head", 2, 1, 1, 0, 40, 32'h4000);
    head(2, 24);
    wait_idle("R6 restart done");
    chk(cp(2) == 24, "R6 cp after restart", cp(2), 24);

    // R9 fixed priority, R1 head write to active channel ignored
    rr_mode = 0;
    desc(64, 0, 32'h7000, 0, 1, SOP | EOP | OWN, 1);
    desc(68, 72, 32'h7300, 0, 3, SOP | EOP | OWN, 3);
    desc(72, 0, 32'h7310, 0, 3, SOP | EOP | OWN, 3);
    desc(76, 80, 32'h7100, 0, 2, SOP | EOP | OWN, 2);
    desc(80, 0, 32'h7110, 0, 2, SOP | EOP | OWN, 2);
    desc(100, 0, 32'h7700, 0, 7, SOP | EOP | OWN, 7);
    expect_x("R9 blocker", 7, 1, 1, 0, 1, 32'h7000);
    expect_x("R9 ch1 first", 1, 1, 1, 0, 2, 32'h7100);
    expect_x("R9 ch1 second", 1, 1, 1, 0, 2, 32'h7110);
    expect_x("R9 ch3 first", 3, 1, 1, 0, 3, 32'h7300);
    expect_x("R9 ch3 second", 3, 1, 1, 0, 3, 32'h7310);
    resp_delay = 60;
    head(7, 64);
    wait_req();
    head(3, 68);
    head(1, 76);
    head(7, 100);
    resp_delay = 2;
    wait_idle("R9 order drained");
    chk(cp(7) == 64 && cp(1) == 80 && cp(3) == 72, "R1 active head write ignored",
        {cp(7), cp(1), cp(3)}, {8'd64, 8'd80, 8'd72});
    chk(ch_err_own[1] == 0, "R1 head clears error", ch_err_own, 0);

    // R10 round-robin
    rr_mode = 1;
    desc(84, 0, 32'h8600, 0, 4, SOP | EOP | OWN, 4);
    desc(88, 92, 32'h8200, 0, 5, SOP | EOP | OWN, 5);
    desc(92, 0, 32'h8210, 0, 5, SOP | EOP | OWN, 5);
    desc(108, 112, 32'h8500, 0, 6, SOP | EOP | OWN, 6);
    desc(112, 0, 32'h8510, 0, 6, SOP | EOP | OWN, 6);
    expect_x("R10 blocker", 6, 1, 1, 0, 4, 32'h8600);
    expect_x("R10 ch2 a", 2, 1, 1, 0, 5, 32'h8200);
    expect_x("R10 ch5 a", 5, 1, 1, 0, 6, 32'h8500);
    expect_x("R10 ch2 b", 2, 1, 1, 0, 5, 32'h8210);
    expect_x("R10 ch5 b", 5, 1, 1, 0, 6, 32'h8510);
    resp_delay = 60;
    head(6, 84);
    wait_req();
    head(2, 88);
    head(5, 108);
    resp_delay = 2;
    wait_idle("R10 order drained");
    chk(ch_err_len[5] == 0, "R1 head clears length error", ch_err_len, 8'h10);

    // R8 teardown mid-packet, and teardown on idle channel
    rr_mode = 0;
    desc(116, 120, 32'h9000, 0, 11, SOP | EOP | OWN, 11);
    desc(120, 124, 32'h9100, 0, 12, SOP | EOP | OWN, 12);
    desc(124, 0, 32'h9200, 0, 13, SOP | EOP | OWN, 13);
    desc(128, 0, 32'h9300, 0, 14, SOP | EOP | OWN, 14);
    expect_x("R8 current packet finishes", 3, 1, 1, 0, 11, 32'h9000);
    resp_delay = 40;
    head(3, 116);
    wait_req();
    tdown(3);
    tdown(0);
    resp_delay = 2;
    wait_idle("R8 nothing after teardown");
    word(123, SOP | EOP | TDN | 12, "R8 teardown flag");
    word(127, SOP | EOP | OWN | 13, "R8 later packet untouched");
    chk(cp(3) == 120 && ch_active[3] == 0, "R8 cp at torn packet", cp(3), 120);
    expect_x("R8 idle teardown ignored", 0, 1, 1, 0, 14, 32'h9300);
    head(0, 128);
    wait_idle("R8 ch0 normal");
    word(131, SOP | EOP | EOQ | 14, "R8 ch0 not torn down");

    // R11 host priority
    for (int j = 0; j < 20; j++) hwr(200 + j, 32'hA500_0000 + j);
    desc(132, 0, 32'hB000, 0, 15, SOP | EOP | OWN, 15);
    expect_x("R11 transfer after burst", 1, 1, 1, 0, 15, 32'hB000);
    head(1, 132);
    for (int j = 0; j <= 20; j++) begin
      if (j > 0) begin
        chk(hst_rdata == 32'hA500_0000 + j - 1, "R11 host read data",
            hst_rdata, 32'hA500_0000 + j - 1);
        chk(!xfer_req, "R11 engine stalled", xfer_req, 0);
      end
      if (j < 20) begin
        hst_en = 1; hst_we = 0; hst_addr = 8'(200 + j);
        @(negedge clk);
      end
    end
    hst_en = 0;
    wait_idle("R11 engine resumes");
    chk(cp(1) == 132, "R11 completion", cp(1), 132);

    report();
  end
endmodule